// File: doc/BRIEF.md
# Cascadable Dual 8-bit Pulse Generator

This block produces rectangular pulse trains from two 8-bit channels. Each channel has its own low-time and high-time reload value. A down-counter loads one of them, counts down on every selected tick, and toggles the output when it reaches zero. The length of each phase is therefore its reload value plus one tick. The period and the duty ratio follow from the two reload values.

A control bit joins the two channels into one 16-bit generator. The low channel's borrow then decrements the high channel, and only a combined zero ends a phase. In this mode both pulse outputs carry the joined waveform. The count tick is picked from several prescaled tick inputs by a select field. A per-channel flag is raised at the end of every completed period, and software clears it with a write.

Top module: `ppg_pair`

## Requirements
- R1: After reset, both pulse outputs and both flags are 0, every reload register is 0, and the control register is 0 (independent mode, tick source 0).
- R2: When a channel is enabled, its output starts low. The first selected tick loads the low reload L. The output stays low for L+1 further ticks, then goes high and loads the high reload H. It stays high for H+1 ticks, then goes low, and the cycle repeats.
- R3: Counting advances only on cycles where `tick_in[s]` is 1, with s taken from control bits [2:1]. Other tick inputs have no effect.
- R4: Register addresses are: 0 = channel 0 low reload, 1 = channel 0 high reload, 2 = channel 1 low reload, 3 = channel 1 high reload, 4 = control (bit 0 joins the channels, bits 2:1 select the tick source), 5 = flag clear.
- R5: A reload value written while a channel runs does not change the phase in progress. It is used from the next load of that phase onward.
- R6: Flag i is set on the tick that ends a high phase of channel i. Writing address 5 with bit i = 1 clears flag i. If a set and a clear fall in the same cycle, the set wins.
- R7: In joined mode, `ch_en[0]` runs one 16-bit generator with low reload {reg2,reg0} and high reload {reg3,reg1}. Both pulse outputs show its waveform, only flag 0 can be set, and `ch_en[1]` is ignored.
- R8: Dropping a channel's enable drives its output low on the next clock. A later enable restarts the channel from a low-phase load.
- R9: In independent mode, each channel uses its own enable, its own reloads and its own flag.
- R10: A reload value of 0 gives a phase that lasts exactly one tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | W | Register write data |
| ch_en | input | 2 | Per-channel run enable |
| tick_in | input | NSRC | Prescaled count tick candidates |
| pulse_o | output | 2 | Pulse outputs |
| irq_o | output | 2 | Period-complete flags |

## Verification
The bench builds the block with W = 8 and NSRC = 4. This keeps single-channel periods short enough to cover many full cycles. Joined mode is run with a low reload above 255, so the byte borrow from the low counter into the high counter is exercised on every low phase. Four tick sources allow both a dense tick (every cycle) and a sparse tick (every third cycle) to be selected while the unused inputs keep toggling.

// File: rtl/ppg_pkg.sv
package ppg_pkg;
    localparam int ADDR_W = 3;
    localparam logic [ADDR_W-1:0] A_LO0  = 3'd0;
    localparam logic [ADDR_W-1:0] A_HI0  = 3'd1;
    localparam logic [ADDR_W-1:0] A_LO1  = 3'd2;
    localparam logic [ADDR_W-1:0] A_HI1  = 3'd3;
    localparam logic [ADDR_W-1:0] A_CTRL = 3'd4;
    localparam logic [ADDR_W-1:0] A_CLR  = 3'd5;
endpackage

// File: rtl/ppg_regs.sv
module ppg_regs
    import ppg_pkg::*;
#(
    parameter int W     = 8,
    parameter int SEL_W = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [W-1:0]          wr_data,
    output logic [1:0][W-1:0]     lo_rel_o,
    output logic [1:0][W-1:0]     hi_rel_o,
    output logic                  cascade_o,
    output logic [SEL_W-1:0]      tick_sel_o,
    output logic [1:0]            clr_o
);
    typedef struct packed {
        logic [1:0][W-1:0] lo;
        logic [1:0][W-1:0] hi;
        logic              casc;
        logic [SEL_W-1:0]  sel;
    } reg_st_t;

    reg_st_t st_d, st_q;

    always_comb begin
        st_d  = st_q;
        clr_o = 2'b00;
        if (wr_en) begin
            case (wr_addr)
                A_LO0:   st_d.lo[0] = wr_data;
                A_HI0:   st_d.hi[0] = wr_data;
                A_LO1:   st_d.lo[1] = wr_data;
                A_HI1:   st_d.hi[1] = wr_data;
                A_CTRL: begin
                    st_d.casc = wr_data[0];
                    st_d.sel  = wr_data[SEL_W:1];
                end
                A_CLR:   clr_o = wr_data[1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lo_rel_o   = st_q.lo;
    assign hi_rel_o   = st_q.hi;
    assign cascade_o  = st_q.casc;
    assign tick_sel_o = st_q.sel;

    AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_addr == A_CTRL) |=> $stable(st_q.casc)); // R4
endmodule

// File: rtl/ppg_slice.sv
module ppg_slice #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         zero_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)     cnt_d = load_val;
        else if (dec) cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero_o = (cnt_q == '0);

    AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !load) |=> cnt_q == W'($past(cnt_q) - 1'b1)); // R2
endmodule

// File: rtl/ppg_phase.sv
module ppg_phase (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic tick,
    input  logic zero,
    input  logic clr,
    output logic load_o,
    output logic sel_hi_o,
    output logic dec_o,
    output logic out_o,
    output logic flag_o
);
    typedef struct packed {
        logic started;
        logic phase;
        logic flag;
    } ph_st_t;

    ph_st_t st_d, st_q;
    logic   set;

    always_comb begin
        st_d     = st_q;
        load_o   = 1'b0;
        sel_hi_o = 1'b0;
        dec_o    = 1'b0;
        set      = 1'b0;
        if (!en) begin
            st_d.started = 1'b0;
            st_d.phase   = 1'b0;
        end else if (tick) begin
            if (!st_q.started) begin
                load_o       = 1'b1;
                st_d.started = 1'b1;
            end else if (zero) begin
                load_o     = 1'b1;
                sel_hi_o   = !st_q.phase;
                st_d.phase = !st_q.phase;
                set        = st_q.phase;
            end else begin
                dec_o = 1'b1;
            end
        end
        st_d.flag = (st_q.flag & ~clr) | set;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_o  = st_q.phase;
    assign flag_o = st_q.flag;

    AST_OFF_IS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !st_q.phase); // R8
    AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.started) |-> !st_q.phase); // R2
    AST_FLAG_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(st_q.phase) && $past(en)) |-> st_q.flag); // R6
endmodule

// File: rtl/ppg_pair.sv
module ppg_pair
    import ppg_pkg::*;
#(
    parameter int W    = 8,
    parameter int NSRC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [W-1:0]      wr_data,
    input  logic [1:0]        ch_en,
    input  logic [NSRC-1:0]   tick_in,
    output logic [1:0]        pulse_o,
    output logic [1:0]        irq_o
);
    localparam int SEL_W = (NSRC > 1) ? $clog2(NSRC) : 1;

    logic [1:0][W-1:0] lo_rel, hi_rel;
    logic              cascade;
    logic [SEL_W-1:0]  tick_sel;
    logic [1:0]        clr;
    logic              tick;

    logic [1:0]        zero, ph_zero, ph_en;
    logic [1:0]        ld, sel_hi, dc, out, flag;
    logic [1:0]        s_load, s_dec;
    logic [1:0][W-1:0] s_val;

    ppg_regs #(.W(W), .SEL_W(SEL_W)) regs_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .lo_rel_o   (lo_rel),
        .hi_rel_o   (hi_rel),
        .cascade_o  (cascade),
        .tick_sel_o (tick_sel),
        .clr_o      (clr)
    );

    assign tick = tick_in[tick_sel];

    for (genvar i = 0; i < 2; i++) begin : g_ch
        if (i == 0) begin : g_lead
            assign ph_en[i]   = ch_en[i];
            assign ph_zero[i] = cascade ? (zero[0] & zero[1]) : zero[0];
            assign s_load[i]  = ld[i];
            assign s_dec[i]   = dc[i];
            assign s_val[i]   = sel_hi[i] ? hi_rel[i] : lo_rel[i];
        end else begin : g_follow
            assign ph_en[i]   = ch_en[i] & ~cascade;
            assign ph_zero[i] = zero[i];
            assign s_load[i]  = cascade ? ld[0] : ld[i];
            assign s_dec[i]   = cascade ? (dc[0] & zero[0]) : dc[i];
            assign s_val[i]   = (cascade ? sel_hi[0] : sel_hi[i]) ? hi_rel[i] : lo_rel[i];
        end

        ppg_slice #(.W(W)) slice_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (s_load[i]),
            .load_val (s_val[i]),
            .dec      (s_dec[i]),
            .zero_o   (zero[i])
        );

        ppg_phase phase_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .en       (ph_en[i]),
            .tick     (tick),
            .zero     (ph_zero[i]),
            .clr      (clr[i]),
            .load_o   (ld[i]),
            .sel_hi_o (sel_hi[i]),
            .dec_o    (dc[i]),
            .out_o    (out[i]),
            .flag_o   (flag[i])
        );
    end

    assign pulse_o[0] = out[0];
    assign pulse_o[1] = cascade ? out[0] : out[1];
    assign irq_o      = flag;

    AST_JOIN_FLAG1_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cascade) && !$past(irq_o[1])) |-> !irq_o[1]); // R7
    AST_IDLE_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (!ch_en[0] && !irq_o[0]) |=> !irq_o[0]); // R8
endmodule

// File: tb/ppg_pair_tb_top.sv
module ppg_pair_tb_top;
    localparam int W = 8;
    localparam int NSRC = 4;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic            rst_n;
    logic            wr_en;
    logic [2:0]      wr_addr;
    logic [W-1:0]    wr_data;
    logic [1:0]      ch_en;
    logic [NSRC-1:0] tick_in;
    logic [1:0]      pulse_o, irq_o;

    ppg_pair #(.W(W), .NSRC(NSRC)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .ch_en(ch_en), .tick_in(tick_in),
        .pulse_o(pulse_o), .irq_o(irq_o)
    );

    int    checks = 0;
    int    errors = 0;
    string req_tag = "R1";
    int    cyc = 0;
    logic [15:0] lfsr = 16'hACE1;

    // reference model state
    int rg[0:3];
    int m_casc, m_sel;
    int st[0:1], ph[0:1], cnt[0:1], fl[0:1];

    task automatic check(string req, logic [1:0] act, logic [1:0] exp, string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b t=%0t", req, what, act, exp, $time);
        end
    endtask

    task automatic gen_step(int g, bit en, bit tk, int lo, int hi, output bit fin);
        fin = 1'b0;
        if (!en) begin
            st[g] = 0; ph[g] = 0;
        end else if (tk) begin
            if (st[g] == 0) begin
                cnt[g] = lo; st[g] = 1;
            end else if (cnt[g] == 0) begin
                if (ph[g] != 0) fin = 1'b1;
                ph[g]  = (ph[g] != 0) ? 0 : 1;
                cnt[g] = (ph[g] != 0) ? hi : lo;
            end else begin
                cnt[g] = cnt[g] - 1;
            end
        end
    endtask

    always @(posedge clk) begin
        bit tk, f0, f1;
        if (!rst_n) begin
            for (int k = 0; k < 4; k++) rg[k] = 0;
            m_casc = 0; m_sel = 0;
            for (int k = 0; k < 2; k++) begin st[k] = 0; ph[k] = 0; cnt[k] = 0; fl[k] = 0; end
        end else begin
            tk = tick_in[m_sel];
            f1 = 1'b0;
            if (m_casc != 0) begin
                gen_step(0, ch_en[0], tk, (rg[2] << 8) | rg[0], (rg[3] << 8) | rg[1], f0);
                st[1] = 0; ph[1] = 0;
            end else begin
                gen_step(0, ch_en[0], tk, rg[0], rg[1], f0);
                gen_step(1, ch_en[1], tk, rg[2], rg[3], f1);
            end
            if (wr_en && wr_addr == 3'd5) begin
                if (wr_data[0]) fl[0] = 0;
                if (wr_data[1]) fl[1] = 0;
            end
            if (f0) fl[0] = 1;
            if (f1) fl[1] = 1;
            if (wr_en) begin
                if (wr_addr < 3'd4) rg[wr_addr] = int'(wr_data);
                else if (wr_addr == 3'd4) begin
                    m_casc = int'(wr_data[0]);
                    m_sel  = int'(wr_data[2:1]);
                end
            end
        end
    end

    // cycle-by-cycle comparison against the model
    always @(posedge clk) begin
        #1;
        if (rst_n) begin
            check(req_tag, pulse_o,
                  {((m_casc != 0) ? ph[0][0] : ph[1][0]), ph[0][0]}, "pulse");
            check(req_tag, irq_o, {fl[1][0], fl[0][0]}, "flag");
        end
    end

    // tick sources: every cycle, every 2nd, every 3rd, pseudo-random
    always @(negedge clk) begin
        cyc++;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        tick_in = {lfsr[0], (cyc % 3 == 0), cyc[0], 1'b1};
    end

    task automatic wr(logic [2:0] a, logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int w;
        rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; ch_en = 2'b00; tick_in = '0;
        idle(5);
        rst_n = 1'b1;
        idle(1);
        check("R1", pulse_o, 2'b00, "reset pulse");
        check("R1", irq_o, 2'b00, "reset flag");

        // R4 R9: independent channels, dense tick
        req_tag = "R9";
        wr(3'd0, 8'd2); wr(3'd1, 8'd3); wr(3'd2, 8'd5); wr(3'd3, 8'd1);
        wr(3'd4, 8'd0);
        ch_en = 2'b11;
        idle(40);
        // R2: high phase width with H=3 and a tick every cycle
        req_tag = "R2";
        while (pulse_o[0] !== 1'b0) @(negedge clk);
        while (pulse_o[0] !== 1'b1) @(negedge clk);
        w = 0;
        while (pulse_o[0] === 1'b1) begin w++; @(negedge clk); end
        check("R2", w[1:0], 2'd0, "high width mod 4");
        check("R2", {1'b0, (w == 4)}, 2'b01, "high width is H+1");
        idle(20);

        // R3: sparse tick source 2
        req_tag = "R3";
        ch_en = 2'b00;
        wr(3'd4, 8'd4);
        ch_en = 2'b11;
        idle(80);

        // R5: reload change mid-run
        req_tag = "R5";
        wr(3'd1, 8'd7);
        idle(10);
        wr(3'd2, 8'd1);
        idle(80);

        // R6: flag clear
        req_tag = "R6";
        wr(3'd5, 8'd3);
        while (irq_o[0] !== 1'b1) @(negedge clk);
        wr(3'd5, 8'd1);
        check("R6", {1'b0, irq_o[0]}, 2'b00, "flag0 after clear");
        idle(60);
        wr(3'd5, 8'd3);

        // R10: zero reloads, dense tick
        req_tag = "R10";
        wr(3'd4, 8'd0);
        wr(3'd0, 8'd0); wr(3'd1, 8'd0);
        idle(20);

        // R8: disable while running
        req_tag = "R8";
        while (pulse_o[0] !== 1'b1) @(negedge clk);
        ch_en[0] = 1'b0;
        idle(1);
        check("R8", {1'b0, pulse_o[0]}, 2'b00, "low after disable");
        idle(3);
        ch_en[0] = 1'b1;
        idle(20);

        // R7: joined 16-bit mode, ch_en[1] held high and ignored
        req_tag = "R7";
        ch_en = 2'b00;
        idle(2);
        wr(3'd0, 8'd3); wr(3'd2, 8'd1); wr(3'd1, 8'd2); wr(3'd3, 8'd0);
        wr(3'd4, 8'd1);
        wr(3'd5, 8'd3);
        ch_en = 2'b11;
        idle(700);
        check("R7", {1'b0, irq_o[1]}, 2'b00, "flag1 quiet when joined");
        check("R7", {1'b0, irq_o[0]}, 2'b01, "flag0 set by joined period");
        ch_en = 2'b00;
        idle(5);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule